// File: doc/BRIEF.md
# Snapshot-Read Register Bank

This block sits behind a narrow read-only CPU port. It lets software see a coherent value for a counter that is wider than the bus, and for a status word that must match the counter. The bank holds three kinds of register. The first is a wide free-running event counter, spread across several consecutive bus-width sub-words and cleared when it is read. The second is a status word that is captured at the same moment as the counter. The third is a status field that is captured whenever an external strobe pin reaches its active level.

A read of sub-word 0 of the counter is the sampling event. In that clock cycle:
- the whole counter is copied into a hold register;
- the companion status word is copied into its own hold register;
- the counter is cleared.

Sub-word 0 itself is returned straight from the live counter. The higher sub-words are later returned from the hold register, so every piece belongs to the same count. The externally sampled field can be stored bit-reversed, and its spare upper bits read as zero.

Read data is registered and arrives one cycle after the request.

Top module: `snapbuf_bank`

## Requirements
- R1: `rd_valid` is high exactly in the cycle after a cycle with `rd_req` high. The data returned for that request appears on `rd_data` in the same cycle. Both outputs are zero while and right after `rst` is high.
- R2: The counter resets to zero, adds one on each clock edge where `cnt_inc` is high, and wraps to zero after its all-ones value.
- R3: A read of address 0 returns bits [BUS_W-1:0] of the live counter value present at the requesting edge. On that same edge, bits [CNT_W-1:BUS_W] of that value are copied into the counter hold register.
- R4: A read of address k, with 1 ≤ k < CNT_W/BUS_W, returns bits [k·BUS_W+BUS_W-1 : k·BUS_W] of the held value. Counting after the sampling event does not change it.
- R5: The counter is zero after every sampling edge, even when `cnt_inc` is high on that edge. Reads of addresses 1 to CNT_W/BUS_W-1 do not clear it.
- R6: Address CNT_W/BUS_W returns the value `stat_a` had at the most recent read of address 0.
- R7: The field hold register loads on an edge where `snap_trig_pin` is at its active level. The active level is 0 when TRIG_ACTIVE_LOW=1 and 1 otherwise. At the inactive level the hold register keeps its value.
- R8: Address CNT_W/BUS_W+1 returns the captured field in bits [STB_FIELD_W-1:0] and zero above. When STB_REVERSED=1, bit i holds `stat_b[STB_FIELD_W-1-i]`.
- R9: Any address above CNT_W/BUS_W+1 returns zero.
- R10: `cnt_sampled` is high in exactly those cycles where `rd_req` is high with `rd_addr` equal to 0.
- R11: Reading a status address any number of times does not change what that address returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_req | input | 1 | Read request for this cycle |
| rd_addr | input | ADDR_W | Sub-word address of the read |
| rd_data | output | BUS_W | Read data, registered |
| rd_valid | output | 1 | Read data valid, one cycle after request |
| cnt_inc | input | 1 | Counter increment enable |
| stat_a | input | BUS_W | Status word sampled together with the counter |
| stat_b | input | STB_FIELD_W | Status field sampled by the external strobe |
| snap_trig_pin | input | 1 | External sampling strobe, polarity set by parameter |
| cnt_sampled | output | 1 | Software-access indication, high in the sampling cycle |

## Verification
The checker watches several properties on every cycle:
- the one-cycle read latency;
- zero data for unmapped addresses;
- sub-word 0 returning the live counter;
- the hold register taking the counter's upper bits at the sampling edge;
- the counter being clear after that edge.

Some behaviours can only be shown by the bench's scenarios:
- a multi-read sequence yielding one coherent count while the counter keeps running;
- the companion status word matching the sampling moment;
- the strobe polarity and the bit-reversed field layout;
- the hold values surviving repeated reads.

// File: rtl/snapbuf_pkg.sv
package snapbuf_pkg;

   // Readback target chosen by address decode
   typedef enum logic [1:0] {
      TGT_CNT  = 2'd0,
      TGT_STA  = 2'd1,
      TGT_STB  = 2'd2,
      TGT_NONE = 2'd3
   } rb_target_e;

endpackage

// File: rtl/snap_counter.sv
module snap_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         inc,
   input  logic         clr,
   output logic [W-1:0] q
);

   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   // clear has priority over increment
   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (clr)
         q <= '0;
      else if (inc)
         q <= q + ONE;
   end

endmodule

// File: rtl/snap_hold.sv
module snap_hold #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   // capture register without reset, holds until next load
   always_ff @(posedge clk) begin
      if (load)
         q <= d;
   end

endmodule

// File: rtl/snap_trig.sv
module snap_trig #(
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic pin,
   output logic fire
);

   generate
      if (ACTIVE_LOW) begin : g_low
         assign fire = ~pin;
      end else begin : g_high
         assign fire = pin;
      end
   endgenerate

endmodule

// File: rtl/snap_readback.sv
module snap_readback
   import snapbuf_pkg::*;
#(
   parameter int BUS_W  = 8,
   parameter int NSUB   = 4,
   parameter int ADDR_W = 3
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      req,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [BUS_W-1:0]          live_lo,
   input  logic [(NSUB-1)*BUS_W-1:0] snap_hi,
   input  logic [BUS_W-1:0]          sta,
   input  logic [BUS_W-1:0]          stb,
   output logic [BUS_W-1:0]          data,
   output logic                      valid
);

   localparam int SUB_W = $clog2(NSUB);
   localparam logic [ADDR_W-1:0] A_STA = ADDR_W'(NSUB);
   localparam logic [ADDR_W-1:0] A_STB = ADDR_W'(NSUB + 1);

   logic [BUS_W-1:0] words [NSUB];
   rb_target_e       tgt;
   logic [BUS_W-1:0] mux;

   // sub-word 0 bypasses the hold register, the rest come from it
   assign words[0] = live_lo;
   generate
      for (genvar k = 1; k < NSUB; k++) begin : g_word
         assign words[k] = snap_hi[(k-1)*BUS_W +: BUS_W];
      end
   endgenerate

   always_comb begin
      if (addr < A_STA)
         tgt = TGT_CNT;
      else if (addr == A_STA)
         tgt = TGT_STA;
      else if (addr == A_STB)
         tgt = TGT_STB;
      else
         tgt = TGT_NONE;

      case (tgt)
         TGT_CNT: mux = words[addr[SUB_W-1:0]];
         TGT_STA: mux = sta;
         TGT_STB: mux = stb;
         default: mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         valid <= 1'b0;
         data  <= '0;
      end else begin
         valid <= req;
         data  <= req ? mux : '0;
      end
   end

endmodule

// File: rtl/snapbuf_bank.sv
module snapbuf_bank #(
   parameter int CNT_W           = 32,
   parameter int BUS_W           = 8,
   parameter int ADDR_W          = 3,
   parameter int STB_FIELD_W     = 6,
   parameter bit STB_REVERSED    = 1'b1,
   parameter bit TRIG_ACTIVE_LOW = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   rd_req,
   input  logic [ADDR_W-1:0]      rd_addr,
   output logic [BUS_W-1:0]       rd_data,
   output logic                   rd_valid,
   input  logic                   cnt_inc,
   input  logic [BUS_W-1:0]       stat_a,
   input  logic [STB_FIELD_W-1:0] stat_b,
   input  logic                   snap_trig_pin,
   output logic                   cnt_sampled
);

   localparam int NSUB = CNT_W / BUS_W;
   localparam int HI_W = CNT_W - BUS_W;

   // elaboration-time parameter checks
   generate
      if (CNT_W % BUS_W != 0) begin : g_err_div
         $error("CNT_W must be a multiple of BUS_W");
      end
      if (NSUB < 2 || (NSUB & (NSUB - 1)) != 0) begin : g_err_nsub
         $error("CNT_W/BUS_W must be a power of two of at least 2");
      end
      if (NSUB + 2 > (1 << ADDR_W)) begin : g_err_addr
         $error("ADDR_W too small for the register map");
      end
      if (STB_FIELD_W < 1 || STB_FIELD_W > BUS_W) begin : g_err_fld
         $error("STB_FIELD_W must be within 1..BUS_W");
      end
   endgenerate

   logic             sample_stb;
   logic             ext_fire;
   logic [CNT_W-1:0] cnt_q;
   logic [HI_W-1:0]  cnt_snap;
   logic [BUS_W-1:0] sta_snap;
   logic [BUS_W-1:0] stb_word;
   logic [BUS_W-1:0] stb_snap;

   // read of the lowest sub-word is the sampling event
   assign sample_stb  = rd_req && (rd_addr == '0);
   assign cnt_sampled = sample_stb;

   snap_counter #(.W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .inc (cnt_inc),
      .clr (sample_stb),
      .q   (cnt_q)
   );

   snap_hold #(.W(HI_W)) u_cnt_hold (
      .clk  (clk),
      .load (sample_stb),
      .d    (cnt_q[CNT_W-1:BUS_W]),
      .q    (cnt_snap)
   );

   snap_hold #(.W(BUS_W)) u_sta_hold (
      .clk  (clk),
      .load (sample_stb),
      .d    (stat_a),
      .q    (sta_snap)
   );

   snap_trig #(.ACTIVE_LOW(TRIG_ACTIVE_LOW)) u_trig (
      .pin  (snap_trig_pin),
      .fire (ext_fire)
   );

   // field placement: optional reversal, zero fill above the field
   generate
      for (genvar b = 0; b < BUS_W; b++) begin : g_stb_bit
         if (b >= STB_FIELD_W) begin : g_pad
            assign stb_word[b] = 1'b0;
         end else if (STB_REVERSED) begin : g_rev
            assign stb_word[b] = stat_b[STB_FIELD_W-1-b];
         end else begin : g_fwd
            assign stb_word[b] = stat_b[b];
         end
      end
   endgenerate

   snap_hold #(.W(BUS_W)) u_stb_hold (
      .clk  (clk),
      .load (ext_fire),
      .d    (stb_word),
      .q    (stb_snap)
   );

   snap_readback #(
      .BUS_W  (BUS_W),
      .NSUB   (NSUB),
      .ADDR_W (ADDR_W)
   ) u_rb (
      .clk     (clk),
      .rst     (rst),
      .req     (rd_req),
      .addr    (rd_addr),
      .live_lo (cnt_q[BUS_W-1:0]),
      .snap_hi (cnt_snap),
      .sta     (sta_snap),
      .stb     (stb_snap),
      .data    (rd_data),
      .valid   (rd_valid)
   );

endmodule

// File: rtl/snapbuf_bank_chk.sv
module snapbuf_bank_chk #(
   parameter int CNT_W  = 32,
   parameter int BUS_W  = 8,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst,
   input logic              rd_req,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [BUS_W-1:0]  rd_data,
   input logic              rd_valid,
   input logic [CNT_W-1:0]  cnt_live,
   input logic [CNT_W-BUS_W-1:0] cnt_snap,
   input logic              sample_stb
);

   localparam int NSUB = CNT_W / BUS_W;
   localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(NSUB + 1);

   // R1
   valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
      rd_req |=> rd_valid);

   // R1
   idle_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
      !rd_req |=> !rd_valid);

   // R9
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_req && rd_addr > A_LAST) |=> rd_data == '0);

   // R3
   live_sub0_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_req && rd_addr == '0) |=> rd_data == $past(cnt_live[BUS_W-1:0]));

   // R3
   snap_capture_chk: assert property (@(posedge clk) disable iff (rst)
      sample_stb |=> cnt_snap == $past(cnt_live[CNT_W-1:BUS_W]));

   // R5
   clear_on_sample_chk: assert property (@(posedge clk) disable iff (rst)
      sample_stb |=> cnt_live == '0);

endmodule

bind snapbuf_bank snapbuf_bank_chk #(
   .CNT_W  (CNT_W),
   .BUS_W  (BUS_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .rd_req     (rd_req),
   .rd_addr    (rd_addr),
   .rd_data    (rd_data),
   .rd_valid   (rd_valid),
   .cnt_live   (cnt_q),
   .cnt_snap   (cnt_snap),
   .sample_stb (sample_stb)
);

// File: tb/snapbuf_bank_bench.sv
module snapbuf_bank_bench;

   localparam int CNT_W = 16;
   localparam int BUS_W = 4;
   localparam int ADDR_W = 3;
   localparam int FW = 3;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             rd_req = 1'b0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [BUS_W-1:0] rd_data;
   logic             rd_valid;
   logic             cnt_inc = 1'b0;
   logic [BUS_W-1:0] stat_a = '0;
   logic [FW-1:0]    stat_b = '0;
   logic             snap_trig_pin = 1'b1;
   logic             cnt_sampled;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   int exp_cnt = 0;
   int exp_snap = 0;

   always #4 clk = ~clk;

   snapbuf_bank #(
      .CNT_W           (CNT_W),
      .BUS_W           (BUS_W),
      .ADDR_W          (ADDR_W),
      .STB_FIELD_W     (FW),
      .STB_REVERSED    (1'b1),
      .TRIG_ACTIVE_LOW (1'b1)
   ) u_snapbuf_bank (
      .clk           (clk),
      .rst           (rst),
      .rd_req        (rd_req),
      .rd_addr       (rd_addr),
      .rd_data       (rd_data),
      .rd_valid      (rd_valid),
      .cnt_inc       (cnt_inc),
      .stat_a        (stat_a),
      .stat_b        (stat_b),
      .snap_trig_pin (snap_trig_pin),
      .cnt_sampled   (cnt_sampled)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // issue one read at a negedge, return data seen after the next edge
   task automatic do_read(input int a, output int d);
      rd_req  = 1'b1;
      rd_addr = ADDR_W'(a);
      #1;
      check("R10 cnt_sampled", int'(cnt_sampled), (a == 0) ? 1 : 0);
      @(negedge clk);
      rd_req = 1'b0;
      check("R1 rd_valid", int'(rd_valid), 1);
      d = int'(rd_data);
   endtask

   // counter sub-word read against the arithmetic model
   task automatic rd_cnt(input int a, input string req);
      int d;
      do_read(a, d);
      if (a == 0) begin
         check(req, d, exp_cnt & 4'hF);
         exp_snap = exp_cnt;
         exp_cnt  = 0;
      end else begin
         check(req, d, (exp_snap >> (4 * a)) & 4'hF);
      end
   endtask

   task automatic pulse_inc(input int n);
      cnt_inc = 1'b1;
      repeat (n) @(negedge clk);
      cnt_inc = 1'b0;
      exp_cnt = (exp_cnt + n) & 16'hFFFF;
   endtask

   function automatic int rev3(input int v);
      int r = 0;
      for (int i = 0; i < FW; i++)
         if (((v >> i) & 1) != 0) r |= 1 << (FW - 1 - i);
      return r;
   endfunction

   initial begin
      int d;
      repeat (3) @(negedge clk);
      check("R1 reset rd_valid", int'(rd_valid), 0);
      check("R1 reset rd_data", int'(rd_data), 0);
      rst = 1'b0;
      @(negedge clk);

      // R2 reset value read through sub-word 0
      rd_cnt(0, "R2 reset count");

      // R3 R4 coherent read while counting between pieces
      pulse_inc(16'h1234);
      rd_cnt(0, "R3 live sub-word 0");
      pulse_inc(77);
      rd_cnt(1, "R4 sub-word 1");
      pulse_inc(5);
      rd_cnt(2, "R4 sub-word 2");
      rd_cnt(3, "R4 sub-word 3");
      // R5 higher sub-word reads do not clear
      rd_cnt(1, "R5 reread sub-word 1");
      rd_cnt(0, "R5 no clear by sub-word reads");
      rd_cnt(0, "R5 cleared after sample");
      // R5 clear wins over increment on the sampling edge
      cnt_inc = 1'b1;
      rd_cnt(0, "R5 sample with inc");
      cnt_inc = 1'b0;
      rd_cnt(0, "R5 clear beats inc");

      // R4 sweep of counts, counting continues between pieces
      for (int i = 0; i < 10; i++) begin
         pulse_inc(i * 523 + 11);
         for (int a = 0; a < 4; a++) begin
            rd_cnt(a, "R4 sweep");
            pulse_inc(i + 1);
         end
      end

      // R6 R11 companion status word, all values
      for (int v = 0; v < 16; v++) begin
         stat_a = BUS_W'(v);
         rd_cnt(0, "R3 sample for status");
         stat_a = ~BUS_W'(v);
         do_read(4, d);
         check("R6 status snapshot", d, v);
         do_read(4, d);
         check("R11 status reread", d, v);
      end

      // R7 R8 external strobe, active low, reversed field
      for (int v = 0; v < 8; v++) begin
         stat_b = FW'(v);
         snap_trig_pin = 1'b0;
         @(negedge clk);
         snap_trig_pin = 1'b1;
         stat_b = ~FW'(v);
         do_read(5, d);
         check("R8 reversed field", d, rev3(v));
         repeat (3) @(negedge clk);
         stat_b = FW'(v ^ 5);
         do_read(5, d);
         check("R7 inactive level holds", d, rev3(v));
         do_read(5, d);
         check("R11 field reread", d, rev3(v));
      end

      // R9 unmapped addresses
      do_read(6, d);
      check("R9 addr 6", d, 0);
      do_read(7, d);
      check("R9 addr 7", d, 0);

      // R1 no request, no valid
      @(negedge clk);
      check("R1 idle rd_valid", int'(rd_valid), 0);

      // R2 wrap-around
      rd_cnt(0, "R2 pre-wrap clear");
      pulse_inc(65537);
      rd_cnt(0, "R2 wrap low");
      rd_cnt(1, "R2 wrap sub1");
      rd_cnt(2, "R2 wrap sub2");
      rd_cnt(3, "R2 wrap sub3");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule